// File: doc/BRIEF.md
# Periodic DRAM Refresh Controller with Bus-Hold Arbitration

This block tells the bus when a DRAM refresh cycle must run and shares the bus with one alternate bus master through a hold request and a hold acknowledge. A programmable down-counter divides the input clock. Each time the counter expires it raises a refresh request, and that request stays latched until a refresh cycle serves it. A refresh cycle lasts a fixed number of clocks. During those clocks the block drives a refresh strobe and a refresh address. The upper seven bits of that address come from a software-written base register and the lower bits from a row counter that steps after every completed refresh.

When the alternate master raises its hold request and nothing is pending, the block grants the bus and keeps the grant for as long as the request stays high. If a refresh falls due while the bus is granted, the block withdraws the grant to ask for the bus back, but it waits until the alternate master actually drops its request before starting the refresh. A hold request that arrives during a refresh is granted only once that refresh has finished. A small write port sets the base, the interval and the enable.

Top module: `refresh_ctrl`

## Requirements
- R1: After reset, hold_ack, rfsh_strobe and rfsh_done are all low, and the enable is clear.
- R2: While enabled with interval value T and no hold, a refresh cycle starts every T+1 clocks, provided T+1 exceeds the cycle length plus one.
- R3: A refresh cycle keeps rfsh_strobe high for exactly CYC_LEN clocks (4 by default), raises rfsh_done in its last clock, and rfsh_strobe is low in the clock that follows.
- R4: rfsh_addr is {base[6:0], row} captured when the cycle starts, and it stays stable while rfsh_strobe is high.
- R5: The row counter rises by one after each completed refresh, wraps from all ones to zero, and keeps its value while the enable is clear.
- R6: While the enable is clear no refresh starts. Clearing it reloads the interval counter and drops a pending request, so a grant withdrawn for that request is given back.
- R7: With no request pending, hold_ack goes high one clock after hold_req is sampled high, stays high while hold_req stays high, and falls one clock after hold_req falls.
- R8: A refresh falling due while the bus is granted drops hold_ack, and no refresh starts while hold_req stays high.
- R9: Once hold_req falls with a refresh pending, rfsh_strobe rises in the next clock.
- R10: hold_req raised during a refresh is not granted until the cycle ends. hold_ack rises in the clock after rfsh_done, and hold_ack and rfsh_strobe are never high together.
- R11: A request raised while another is pending or in service is kept and served. With T=0 refreshes run back to back, one every CYC_LEN+1 clocks.
- R12: Register writes use reg_wr with reg_addr: 0 writes base from reg_wdata[6:0], 1 writes the interval from reg_wdata[PRESC_W-1:0], and 2 writes the enable from reg_wdata[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 interval, 2 enable |
| reg_wdata | input | 9 | Write data (max of base and interval widths) |
| hold_req | input | 1 | Bus request from the alternate master |
| hold_ack | output | 1 | Bus grant to the alternate master |
| rfsh_strobe | output | 1 | High during each refresh cycle |
| rfsh_addr | output | 16 | Refresh address {base, row} |
| rfsh_done | output | 1 | Last clock of a refresh cycle |

## Verification
The assertions check on every cycle the properties that hold from one clock to the next. These are: grant and strobe are never high together, a refresh never starts from the granted state while the request is still high, the grant falls after the request drops, a request is latched, and clearing the enable drops it. They also check that the address stays stable within a cycle, that the row steps by one on each done, and that the strobe is low after done. Only the bench scenarios can show the things that need a whole sequence. These are the exact refresh interval for a given prescaler value, the give-back of the bus after the alternate master releases it, and the wrap of the row counter over a full pass. They also include the retained row across a disable, and the back-to-back spacing when requests pile up.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HELD = 2'd1,
    ST_RFSH = 2'd2
  } rf_state_e;

  localparam logic [1:0] RA_BASE  = 2'd0;
  localparam logic [1:0] RA_TIMER = 2'd1;
  localparam logic [1:0] RA_CTRL  = 2'd2;
endpackage

// File: rtl/rfsh_prescaler.sv
module rfsh_prescaler #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] reload,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  function automatic logic [W-1:0] dec_cnt(input logic [W-1:0] v);
    return v - W'(1);
  endfunction

  assign tick = en && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!en)         cnt_q <= reload;
    else if (cnt_q == '0) cnt_q <= reload;
    else                  cnt_q <= dec_cnt(cnt_q);
  end
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] row
);
  function automatic logic [W-1:0] row_step(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   row <= '0;
    else if (adv) row <= row_step(row);
  end
endmodule

// File: rtl/rfsh_arbiter.sv
module rfsh_arbiter
  import rfsh_pkg::*;
#(
  parameter int CYC_LEN = 4,
  localparam int CW = $clog2(CYC_LEN + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      tick,
  input  logic      hold,
  output rf_state_e state,
  output logic      pend,
  output logic      start,
  output logic      done
);
  rf_state_e nxt;
  logic [CW-1:0] cyc_q;

  assign done  = (state == ST_RFSH) && (cyc_q == CW'(CYC_LEN - 1));
  assign start = (state != ST_RFSH) && (nxt == ST_RFSH);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (pend) nxt = ST_RFSH;
               else if (hold) nxt = ST_HELD;
      ST_HELD: if (!hold) nxt = pend ? ST_RFSH : ST_IDLE;
      ST_RFSH: if (done) nxt = hold ? ST_HELD : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pend  <= 1'b0;
      cyc_q <= '0;
    end else begin
      state <= nxt;
      if (!en)        pend <= 1'b0;
      else if (tick)  pend <= 1'b1;
      else if (start) pend <= 1'b0;
      if (state == ST_RFSH && !done) cyc_q <= cyc_q + CW'(1);
      else                           cyc_q <= '0;
    end
  end
endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import rfsh_pkg::*;
#(
  parameter int BASE_W  = 7,
  parameter int ROW_W   = 9,
  parameter int PRESC_W = 9,
  parameter int CYC_LEN = 4,
  localparam int ADDR_W = BASE_W + ROW_W,
  localparam int WD_W   = (BASE_W > PRESC_W) ? BASE_W : PRESC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [WD_W-1:0]   reg_wdata,
  input  logic              hold_req,
  output logic              hold_ack,
  output logic              rfsh_strobe,
  output logic [ADDR_W-1:0] rfsh_addr,
  output logic              rfsh_done
);
  logic [BASE_W-1:0]  base_q;
  logic [PRESC_W-1:0] timer_q;
  logic               en_q;
  logic               tick_w, pend_w, start_w, done_w, held_w;
  logic [ROW_W-1:0]   row_w;
  logic [ADDR_W-1:0]  addr_q;
  rf_state_e          state_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      timer_q <= '0;
      en_q    <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_BASE:  base_q  <= reg_wdata[BASE_W-1:0];
        RA_TIMER: timer_q <= reg_wdata[PRESC_W-1:0];
        RA_CTRL:  en_q    <= reg_wdata[0];
        default:  ;
      endcase
    end
  end

  rfsh_prescaler #(.W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .en(en_q), .reload(timer_q), .tick(tick_w)
  );

  rfsh_arbiter #(.CYC_LEN(CYC_LEN)) u_arb (
    .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick_w), .hold(hold_req),
    .state(state_w), .pend(pend_w), .start(start_w), .done(done_w)
  );

  rfsh_row_ctr #(.W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .adv(done_w), .row(row_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       addr_q <= '0;
    else if (start_w) addr_q <= {base_q, row_w};
  end

  assign held_w      = (state_w == ST_HELD);
  assign hold_ack    = held_w && !pend_w;
  assign rfsh_strobe = (state_w == ST_RFSH);
  assign rfsh_done   = done_w;
  assign rfsh_addr   = addr_q;
endmodule

// File: rtl/refresh_ctrl_chk.sv
module refresh_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int ROW_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold_req,
  input logic              hold_ack,
  input logic              rfsh_strobe,
  input logic              rfsh_done,
  input logic [ADDR_W-1:0] rfsh_addr,
  input logic              tick,
  input logic              pend,
  input logic              en,
  input logic              held,
  input logic [ROW_W-1:0]  row
);
  a_r3_strobe_low_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_done |=> !rfsh_strobe);

  a_r10_no_grant_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    !(rfsh_strobe && hold_ack));

  a_r7_grant_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !hold_req) |=> !hold_ack);

  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_strobe && $past(rfsh_strobe)) |-> $stable(rfsh_addr));

  a_r5_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_done |=> (row == ROW_W'($past(row) + 1'b1)));

  a_r11_request_latched: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pend);

  a_r6_disable_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pend);

  a_r8_no_refresh_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (held && hold_req) |=> !rfsh_strobe);

  a_r2_start_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_strobe) |-> $past(pend));
endmodule

bind refresh_ctrl refresh_ctrl_chk #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_ack(hold_ack),
  .rfsh_strobe(rfsh_strobe), .rfsh_done(rfsh_done), .rfsh_addr(rfsh_addr),
  .tick(tick_w), .pend(pend_w), .en(en_q), .held(held_w), .row(row_w)
);

// File: tb/tb_refresh_ctrl.sv
`timescale 1ns/1ps
module tb_refresh_ctrl;
  localparam int CYC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [8:0]  reg_wdata = '0;
  logic        hold_req = 1'b0;
  logic        hold_ack, rfsh_strobe, rfsh_done;
  logic [15:0] rfsh_addr;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [6:0] exp_base = '0;
  logic [8:0] exp_row = '0;
  bit  m_prev = 0, m_prev_done = 0, wrap_seen = 0;
  int  run = 0, done_cnt = 0;

  always #2 clk = ~clk;

  refresh_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .hold_req(hold_req), .hold_ack(hold_ack),
    .rfsh_strobe(rfsh_strobe), .rfsh_addr(rfsh_addr), .rfsh_done(rfsh_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // address, length and row model on every refresh cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (rfsh_strobe && !m_prev) begin
        run = 1;
        chk(rfsh_addr == {exp_base, exp_row}, "R4/R5", "refresh address",
            rfsh_addr, {exp_base, exp_row});
      end else if (rfsh_strobe) run++;
      if (m_prev_done)
        chk(!rfsh_strobe, "R3", "strobe after done", rfsh_strobe, 0);
      if (rfsh_done) begin
        chk(run == CYC, "R3", "strobe length", run, CYC);
        if (exp_row == 9'h1FF) wrap_seen = 1;
        exp_row = exp_row + 9'd1;
        done_cnt++;
      end
      m_prev = rfsh_strobe;
      m_prev_done = rfsh_done;
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [8:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    if (a == 2'd0) exp_base = d[6:0];
  endtask

  task automatic set_hold(input logic v);
    @(posedge clk); #1 hold_req = v;
  endtask

  task automatic wait_rise(input int lim, output int n);
    bit p = rfsh_strobe;
    n = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (rfsh_strobe && !p) begin n = i; return; end
      p = rfsh_strobe;
    end
  endtask

  task automatic quiesce();
    wr_reg(2'd2, 9'd0);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!hold_ack && !rfsh_strobe && !rfsh_done, "R1", "outputs in reset",
        {hold_ack, rfsh_strobe, rfsh_done}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(!rfsh_strobe, "R1", "no refresh before enable", rfsh_strobe, 0);
  endtask

  task automatic t_period();
    int n;
    wr_reg(2'd0, 9'h55);
    wr_reg(2'd1, 9'd19);
    wr_reg(2'd2, 9'd1);
    wait_rise(60, n);
    chk(n > 0, "R2", "first refresh seen", n, 1);
    wait_rise(60, n);
    chk(n == 20, "R2", "interval T=19", n, 20);
    wr_reg(2'd1, 9'd5);
    wait_rise(60, n);
    wait_rise(60, n);
    chk(n == 6, "R2", "interval T=5", n, 6);
    quiesce();
  endtask

  task automatic t_disable();
    int cnt = 0;
    logic [8:0] saved = exp_row;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rfsh_strobe) cnt++;
    end
    chk(cnt == 0, "R6", "strobes while disabled", cnt, 0);
    chk(exp_row == saved, "R5", "row kept while disabled", exp_row, saved);
  endtask

  task automatic t_base();
    int n;
    wr_reg(2'd0, 9'h2A);
    wr_reg(2'd1, 9'd7);
    wr_reg(2'd2, 9'd1);
    wait_rise(40, n);
    chk(rfsh_addr[15:9] == 7'h2A, "R12", "base field", rfsh_addr[15:9], 7'h2A);
    quiesce();
  endtask

  task automatic t_hold_idle();
    int bad = 0;
    set_hold(1'b1);
    @(negedge clk);
    chk(!hold_ack, "R7", "ack not yet", hold_ack, 0);
    @(negedge clk);
    chk(hold_ack, "R7", "ack one clock after request", hold_ack, 1);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!hold_ack) bad++;
    end
    chk(bad == 0, "R7", "ack held while requested", bad, 0);
  endtask

  task automatic t_hold_refresh();
    int waitn = -1, bad = 0;
    logic [8:0] row_before = exp_row;
    wr_reg(2'd1, 9'd9);
    wr_reg(2'd2, 9'd1);
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (!hold_ack) begin waitn = i; break; end
    end
    chk(waitn > 0, "R8", "ack withdrawn for refresh", waitn, 1);
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (rfsh_strobe || hold_ack) bad++;
    end
    chk(bad == 0, "R8", "no refresh while hold stays", bad, 0);
    set_hold(1'b0);
    @(negedge clk);
    chk(!rfsh_strobe, "R9", "strobe not before edge", rfsh_strobe, 0);
    @(negedge clk);
    chk(rfsh_strobe, "R9", "strobe after hold drops", rfsh_strobe, 1);
    chk(rfsh_addr[8:0] == row_before, "R11", "pending request served",
        rfsh_addr[8:0], row_before);
    quiesce();
  endtask

  task automatic t_hold_mid();
    int n, bad = 0;
    wr_reg(2'd1, 9'd19);
    wr_reg(2'd2, 9'd1);
    wait_rise(60, n);
    set_hold(1'b1);
    for (int i = 0; i < 10 && !rfsh_done; i++) begin
      @(negedge clk);
      if (hold_ack) bad++;
    end
    chk(bad == 0, "R10", "no grant inside refresh", bad, 0);
    chk(rfsh_done, "R10", "refresh completed", rfsh_done, 1);
    @(negedge clk);
    chk(hold_ack && !rfsh_strobe, "R10", "grant after done",
        {hold_ack, rfsh_strobe}, 2);
    set_hold(1'b0);
    quiesce();
  endtask

  task automatic t_disable_pending();
    int waitn = -1, cnt = 0;
    set_hold(1'b1);
    repeat (3) @(negedge clk);
    wr_reg(2'd1, 9'd4);
    wr_reg(2'd2, 9'd1);
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (!hold_ack) begin waitn = i; break; end
    end
    chk(waitn > 0, "R8", "ack withdrawn", waitn, 1);
    wr_reg(2'd2, 9'd0);
    @(negedge clk);
    @(negedge clk);
    chk(hold_ack, "R6", "grant returned after disable", hold_ack, 1);
    set_hold(1'b0);
    @(negedge clk);
    @(negedge clk);
    chk(!hold_ack, "R7", "ack falls after release", hold_ack, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rfsh_strobe) cnt++;
    end
    chk(cnt == 0, "R6", "dropped request not served", cnt, 0);
  endtask

  task automatic t_wrap();
    int n, target;
    wr_reg(2'd1, 9'd0);
    wr_reg(2'd2, 9'd1);
    wait_rise(20, n);
    wait_rise(20, n);
    chk(n == CYC + 1, "R11", "back-to-back spacing", n, CYC + 1);
    target = done_cnt + 520;
    for (int i = 0; i < 4000 && done_cnt < target; i++) @(negedge clk);
    chk(wrap_seen, "R5", "row wrapped to zero", wrap_seen, 1);
    quiesce();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_period();
    t_disable();
    t_base();
    t_hold_idle();
    t_hold_refresh();
    t_hold_mid();
    t_disable_pending();
    t_wrap();
    repeat (5) @(negedge clk);
    summary();
  end
endmodule